// File: doc/BRIEF.md
# Locked Atomic Access Arbiter

This block shares one memory bus among several requesting agents and runs locked read-modify-write sequences. Each requester presents a request with an address, an access size in bytes, a write-back cacheable attribute, a lock flag and an exchange flag. It also presents a signal that tells the arbiter whether its buffered writes have drained. The arbiter grants the bus to one requester at a time. A plain access keeps its grant until the bus reports completion. A locked access keeps its grant through a read phase and then a write phase.

For each locked access the block decides between two ways of handling it. If the access targets write-back cacheable memory and fits inside one 64-byte line, it is handled as a cache lock: the access is atomic, but the lock output stays low. Otherwise the block raises the bus lock output for the whole read-modify-write. Other agents are shut out in both cases, because the grant is not given to anyone else until the sequence ends. No locked access is granted to a requester whose write buffer still holds data. Coherency and the atomic data path belong to the surrounding system.

Top module: `lkarb_top`

## Requirements
- R1: During and directly after reset, no grant is given and bus_lock, atomic_op and rmw_write are low.
- R2: A locked request with req_wb=1 whose byte offset within its 64-byte line (address bits 5:0) plus its size is at most 64 is granted with atomic_op=1 and bus_lock=0.
- R3: A locked request whose offset (address bits 5:0) plus size exceeds 64 raises bus_lock in the grant cycle. The lock stays high until the sequence ends. An access that ends exactly on byte 63 of the line does not count as crossing.
- R4: A locked request with req_wb=0 raises bus_lock, whatever its alignment.
- R5: A request with req_xchg=1 is handled as locked (atomic_op=1) even when req_lock=0.
- R6: A locked or exchange request is not granted while its wbuf_empty bit is 0. Other requesters may be granted meanwhile. Once the bit is 1, the request becomes eligible.
- R7: While bus_lock is high, the grant does not move to any other requester.
- R8: A locked sequence stays in its read phase (rmw_write=0) until the first bus_done. It then stays in its write phase (rmw_write=1) until the next bus_done. In the cycle after that second bus_done, bus_lock, atomic_op and the grant are all low.
- R9: Grants go round-robin. The search starts at the requester after the most recently granted one and wraps around. After reset the search starts at requester 0.
- R10: A plain access keeps its grant until bus_done. The grant is low in the following cycle, and a new grant can appear at the earliest one cycle later.
- R11: At most one grant bit is high at any time, so locked sequences from different agents never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 4 | Request pending, one bit per requester |
| req_addr | input | 128 | Byte addresses, 32 bits per requester, requester i at bits i*32 upward |
| req_size | input | 20 | Access sizes in bytes, 5 bits per requester |
| req_wb | input | 4 | Target is write-back cacheable |
| req_lock | input | 4 | Request is a locked read-modify-write |
| req_xchg | input | 4 | Request is an exchange (always locked) |
| wbuf_empty | input | 4 | Requester's buffered writes have drained |
| bus_done | input | 1 | Current bus phase completes this cycle |
| gnt | output | 4 | One-hot bus grant |
| bus_lock | output | 1 | Bus lock held for the current sequence |
| atomic_op | output | 1 | Granted access is a locked read-modify-write |
| rmw_write | output | 1 | Locked sequence is in its write phase |

## Verification
Directed cases separate the two lock decisions by flipping one attribute at a time. The inputs used are an aligned cacheable access, an uncacheable access, a crossing access, an access ending exactly at the line edge, and an exchange whose lock flag is clear. Each case shows which rule decided bus_lock. One case holds a locked requester back with undrained writes while a plain requester is present, which shows that the drain gate affects only the locked requester. Four simultaneous plain requests expose the rotation order and the idle gap. Seeded random traffic then mixes all of these attributes, drain states and completion timings against a cycle model of the grant sequence.

// File: rtl/lkarb_pkg.sv
// Package: shared types for the locked access arbiter.
// Assumes: nothing beyond the 1800-2017 type system.
package lkarb_pkg;

    // Sequencer state: idle, plain transfer, locked read phase, locked write phase
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } arb_state_t;

endpackage

// File: rtl/lkarb_classify.sv
// Module: lkarb_classify
// Sorts one requester's request as plain, cache-locked or bus-locked.
// Also decides whether the request may compete for the bus this cycle.
// Assumes: sizes are byte counts and the line is 2**LINE_LOG2 bytes.
module lkarb_classify #(
    parameter int AW        = 32,
    parameter int SZW       = 5,
    parameter int LINE_LOG2 = 6
) (
    input  logic [AW-1:0]  addr,
    input  logic [SZW-1:0] size,
    input  logic           valid,
    input  logic           wb,
    input  logic           lock_flag,
    input  logic           xchg,
    input  logic           drained,
    output logic           is_locked,
    output logic           need_bus_lock,
    output logic           eligible
);
    localparam int LINE_BYTES = 1 << LINE_LOG2;
    localparam int EW = ((LINE_LOG2 > SZW) ? LINE_LOG2 : SZW) + 2;

    logic [LINE_LOG2-1:0] offset;
    logic [EW-1:0]        end_sum;
    logic                 crosses;
    logic                 unused_addr_hi;

    assign offset         = addr[LINE_LOG2-1:0];
    assign unused_addr_hi = ^addr[AW-1:LINE_LOG2];

    // Line-crossing test: the offset plus the size runs past the end of the line
    always_comb begin
        end_sum = EW'(offset) + EW'(size);
        crosses = end_sum > EW'(LINE_BYTES);
    end

    // Lock kind: an exchange is locked regardless of its flag
    always_comb begin
        is_locked     = lock_flag | xchg;
        need_bus_lock = is_locked & ~(wb & ~crosses);
    end

    // Eligibility: a locked request waits for its write buffer to drain
    always_comb begin
        eligible = valid & (~is_locked | drained);
    end
endmodule

// File: rtl/lkarb_rr.sv
// Module: lkarb_rr
// Round-robin picker. Searches from the requester after the last winner.
// Assumes: 'take' is high only when the picked winner is actually granted.
module lkarb_rr #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    input  logic          take,
    output logic          found,
    output logic [IW-1:0] win
);
    logic [IW-1:0] last_q;

    // Cyclic search for the first eligible requester after last_q
    always_comb begin
        int            idx;
        logic [IW-1:0] idx_w;
        found = 1'b0;
        win   = '0;
        for (int k = 1; k <= N; k++) begin
            idx   = (int'(last_q) + k) % N;
            idx_w = IW'(idx);
            if (!found && elig[idx_w]) begin
                found = 1'b1;
                win   = idx_w;
            end
        end
    end

    // Pointer update: remember who won, so requester 0 leads after reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IW'(N - 1);
        else if (take)
            last_q <= win;
    end

    // R9: a granted winner was eligible when it was picked
    a_r9_win_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> found && elig[win]);
endmodule

// File: rtl/lkarb_ctrl.sv
// Module: lkarb_ctrl
// Grant sequencer. Holds one owner through a plain transfer or through the
// read and write phases of a locked sequence, and drives the lock output.
// Assumes: bus_done pulses once for each completed bus phase of the owner.
module lkarb_ctrl
    import lkarb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          found,
    input  logic [IW-1:0] win,
    input  logic [N-1:0]  locked_vec,
    input  logic [N-1:0]  buslock_vec,
    input  logic          bus_done,
    output logic          take,
    output logic [N-1:0]  gnt,
    output logic          bus_lock,
    output logic          atomic_op,
    output logic          rmw_write
);
    arb_state_t    state_q;
    logic [IW-1:0] owner_q;
    logic          lock_q;
    logic          atom_q;

    assign take      = (state_q == ST_IDLE) && found;
    assign bus_lock  = lock_q;
    assign atomic_op = atom_q;
    assign rmw_write = (state_q == ST_WR);

    // Grant decode: one-hot owner whenever a sequence is active
    always_comb begin
        gnt = '0;
        if (state_q != ST_IDLE)
            gnt[owner_q] = 1'b1;
    end

    // Sequencer: accept a winner in idle, then step through its phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            lock_q  <= 1'b0;
            atom_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (found) begin
                        owner_q <= win;
                        atom_q  <= locked_vec[win];
                        lock_q  <= buslock_vec[win];
                        state_q <= locked_vec[win] ? ST_RD : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (bus_done)
                        state_q <= ST_IDLE;
                end
                ST_RD: begin
                    if (bus_done)
                        state_q <= ST_WR;
                end
                ST_WR: begin
                    if (bus_done) begin
                        state_q <= ST_IDLE;
                        lock_q  <= 1'b0;
                        atom_q  <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R11: never more than one owner
    a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R7: the grant cannot move while the bus lock is held
    a_r7_lock_holds_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && $past(bus_lock)) |-> $stable(gnt));

    // R8: the write-phase completion frees the lock and the bus next cycle
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_write && bus_done) |=> (!bus_lock && !atomic_op && gnt == '0));

    // R10: a plain transfer leaves one idle cycle after completion
    a_r10_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && !atomic_op && bus_done) |=> gnt == '0);

    // R3: a held lock always belongs to an active locked owner
    a_r3_lock_owned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> (atomic_op && gnt != '0));
endmodule

// File: rtl/lkarb_top.sv
// Module: lkarb_top
// Bus arbiter with locked read-modify-write support. Each requester gets a
// classifier, one picker chooses the next owner, and a sequencer holds it.
// Assumes: requests stay steady until granted; attributes are captured then.
module lkarb_top #(
    parameter int N         = 4,
    parameter int AW        = 32,
    parameter int SZW       = 5,
    parameter int LINE_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_valid,
    input  logic [N*AW-1:0]  req_addr,
    input  logic [N*SZW-1:0] req_size,
    input  logic [N-1:0]     req_wb,
    input  logic [N-1:0]     req_lock,
    input  logic [N-1:0]     req_xchg,
    input  logic [N-1:0]     wbuf_empty,
    input  logic             bus_done,
    output logic [N-1:0]     gnt,
    output logic             bus_lock,
    output logic             atomic_op,
    output logic             rmw_write
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  locked_vec;
    logic [N-1:0]  buslock_vec;
    logic [N-1:0]  elig_vec;
    logic          found;
    logic [IW-1:0] win;
    logic          take;

    // One classifier per requester
    for (genvar i = 0; i < N; i++) begin : g_cls
        lkarb_classify #(
            .AW(AW), .SZW(SZW), .LINE_LOG2(LINE_LOG2)
        ) u_cls (
            .addr          (req_addr[i*AW +: AW]),
            .size          (req_size[i*SZW +: SZW]),
            .valid         (req_valid[i]),
            .wb            (req_wb[i]),
            .lock_flag     (req_lock[i]),
            .xchg          (req_xchg[i]),
            .drained       (wbuf_empty[i]),
            .is_locked     (locked_vec[i]),
            .need_bus_lock (buslock_vec[i]),
            .eligible      (elig_vec[i])
        );
    end

    lkarb_rr #(.N(N), .IW(IW)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig_vec),
        .take  (take),
        .found (found),
        .win   (win)
    );

    lkarb_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .found       (found),
        .win         (win),
        .locked_vec  (locked_vec),
        .buslock_vec (buslock_vec),
        .bus_done    (bus_done),
        .take        (take),
        .gnt         (gnt),
        .bus_lock    (bus_lock),
        .atomic_op   (atomic_op),
        .rmw_write   (rmw_write)
    );

    // R6: a fresh locked grant went to a requester whose writes had drained
    a_r6_drained_first: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && $past(gnt) == '0 && atomic_op) |-> (($past(wbuf_empty) & gnt) != '0));
endmodule

// File: tb/lkarb_top_test.sv
// Bench for lkarb_top. It runs directed corner cases first and then seeded
// random traffic. Every cycle it compares the outputs with a cycle model.
module lkarb_top_test;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req_valid, req_wb, req_lock, req_xchg, wbuf_empty;
    logic [127:0]  req_addr;
    logic [19:0]   req_size;
    logic          bus_done;
    logic [N-1:0]  gnt;
    logic          bus_lock, atomic_op, rmw_write;

    logic [31:0] a_addr [N];
    logic [4:0]  a_size [N];
    logic        a_v [N], a_wb [N], a_lk [N], a_xg [N], a_dr [N];

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Cycle model state: 0 idle, 1 plain, 2 locked read, 3 locked write
    int m_st, m_own, m_last;
    bit m_lock, m_atom;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            req_addr[i*32 +: 32] = a_addr[i];
            req_size[i*5 +: 5]   = a_size[i];
            req_valid[i] = a_v[i];
            req_wb[i]    = a_wb[i];
            req_lock[i]  = a_lk[i];
            req_xchg[i]  = a_xg[i];
            wbuf_empty[i] = a_dr[i];
        end
    end

    lkarb_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_wb(req_wb), .req_lock(req_lock),
        .req_xchg(req_xchg), .wbuf_empty(wbuf_empty), .bus_done(bus_done),
        .gnt(gnt), .bus_lock(bus_lock), .atomic_op(atomic_op), .rmw_write(rmw_write)
    );

    function automatic bit f_locked(int i);
        return a_lk[i] | a_xg[i];
    endfunction

    function automatic bit f_buslock(int i);
        bit crosses;
        crosses = (int'(a_addr[i][5:0]) + int'(a_size[i])) > 64;
        return f_locked(i) && !(a_wb[i] && !crosses);
    endfunction

    function automatic bit f_elig(int i);
        return a_v[i] && (!f_locked(i) || a_dr[i]);
    endfunction

    function automatic logic [N-1:0] f_gnt();
        logic [N-1:0] g;
        g = '0;
        if (m_st != 0) g[m_own] = 1'b1;
        return g;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // One clock: advance the model on current inputs, then compare
    task automatic step();
        int  n_st, n_own, n_last;
        bit  n_lock, n_atom, hit;
        n_st = m_st; n_own = m_own; n_last = m_last; n_lock = m_lock; n_atom = m_atom;
        case (m_st)
            0: begin
                hit = 0;
                for (int k = 1; k <= N; k++) begin
                    int idx;
                    idx = (m_last + k) % N;
                    if (!hit && f_elig(idx)) begin
                        hit = 1; n_own = idx; n_last = idx;
                        n_atom = f_locked(idx); n_lock = f_buslock(idx);
                        n_st = n_atom ? 2 : 1;
                    end
                end
            end
            1: if (bus_done) n_st = 0;
            2: if (bus_done) n_st = 3;
            default: if (bus_done) begin n_st = 0; n_lock = 0; n_atom = 0; end
        endcase
        @(posedge clk);
        m_st = n_st; m_own = n_own; m_last = n_last; m_lock = n_lock; m_atom = n_atom;
        @(negedge clk);
        chk("R9 grant", 32'(gnt), 32'(f_gnt()));
        chk("R3 bus_lock", 32'(bus_lock), 32'(m_lock));
        chk("R5 atomic_op", 32'(atomic_op), 32'(m_atom));
        chk("R8 rmw_write", 32'(rmw_write), 32'(m_st == 3));
    endtask

    task automatic set_req(int i, bit v, logic [31:0] ad, logic [4:0] sz,
                           bit wb, bit lk, bit xg, bit dr);
        a_v[i] = v; a_addr[i] = ad; a_size[i] = sz;
        a_wb[i] = wb; a_lk[i] = lk; a_xg[i] = xg; a_dr[i] = dr;
    endtask

    task automatic finish_op(int own);
        a_v[own] = 0;
        bus_done = 1;
        while (m_st != 0) step();
        bus_done = 0;
    endtask

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 0; bus_done = 0;
        for (int i = 0; i < N; i++) set_req(i, 0, 0, 1, 0, 0, 0, 1);
        m_st = 0; m_own = 0; m_last = N - 1; m_lock = 0; m_atom = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset gnt", 32'(gnt), 0);
        chk("R1 reset lock", 32'(bus_lock), 0);
        chk("R1 reset atomic", 32'(atomic_op), 0);
        chk("R1 reset wr", 32'(rmw_write), 0);
        rst_n = 1;
        step();
        chk("R1 after reset gnt", 32'(gnt), 0);

        // R2: aligned cacheable locked access -> cache lock
        set_req(0, 1, 32'h100, 4, 1, 1, 0, 1);
        step();
        chk("R2 gnt", 32'(gnt), 1);
        chk("R2 atomic", 32'(atomic_op), 1);
        chk("R2 no bus lock", 32'(bus_lock), 0);
        chk("R8 read phase", 32'(rmw_write), 0);
        a_v[0] = 0; bus_done = 1;
        step();
        chk("R8 write phase", 32'(rmw_write), 1);
        step();
        chk("R8 idle after write", 32'(gnt), 0);
        bus_done = 0;

        // R4 and R7: uncacheable lock blocks a waiting plain requester
        set_req(1, 1, 32'h200, 8, 0, 1, 0, 1);
        set_req(2, 1, 32'h0, 4, 1, 0, 0, 1);
        step();
        chk("R4 bus lock", 32'(bus_lock), 1);
        a_v[1] = 0;
        step();
        chk("R7 held grant", 32'(gnt), 32'h2);
        step();
        chk("R7 held grant", 32'(gnt), 32'h2);
        bus_done = 1;
        step();
        chk("R8 lock in write phase", 32'(bus_lock), 1);
        step();
        chk("R8 lock released", 32'(bus_lock), 0);
        chk("R8 grant released", 32'(gnt), 0);
        bus_done = 0;
        step();
        chk("R9 next after 1", 32'(gnt), 32'h4);
        a_v[2] = 0; bus_done = 1;
        step();
        chk("R10 gap after plain", 32'(gnt), 0);
        bus_done = 0;

        // R3: crossing (62+4) vs exactly fitting (60+4)
        set_req(3, 1, 32'h3E, 4, 1, 1, 0, 1);
        step();
        chk("R3 crossing lock", 32'(bus_lock), 1);
        finish_op(3);
        set_req(0, 1, 32'h3C, 4, 1, 1, 0, 1);
        step();
        chk("R3 edge no lock", 32'(bus_lock), 0);
        chk("R3 edge atomic", 32'(atomic_op), 1);
        finish_op(0);

        // R5: exchange with lock flag clear
        set_req(1, 1, 32'h40, 4, 0, 0, 1, 1);
        step();
        chk("R5 xchg atomic", 32'(atomic_op), 1);
        chk("R5 xchg lock", 32'(bus_lock), 1);
        finish_op(1);

        // R6: undrained locked requester waits, plain one proceeds
        set_req(3, 1, 32'h0, 4, 1, 1, 0, 0);
        set_req(0, 1, 32'h80, 4, 1, 0, 0, 1);
        step();
        chk("R6 plain passes", 32'(gnt), 32'h1);
        finish_op(0);
        step();
        chk("R6 held off", 32'(gnt), 0);
        a_dr[3] = 1;
        step();
        chk("R6 granted once drained", 32'(gnt), 32'h8);
        finish_op(3);

        // R9 and R10: four plain requests rotate with an idle gap each
        for (int i = 0; i < N; i++) set_req(i, 1, 32'(i * 64), 4, 1, 0, 0, 1);
        for (int k = 0; k < N; k++) begin
            step();
            chk("R9 rotation", 32'(gnt), 32'(1 << k));
            a_v[k] = 0; bus_done = 1;
            step();
            chk("R10 gap", 32'(gnt), 0);
            bus_done = 0;
        end

        // Random traffic checked against the model (R11 via one-hot grant)
        for (int c = 0; c < 4000; c++) begin
            bus_done = ($urandom % 3) == 0;
            for (int i = 0; i < N; i++) begin
                a_dr[i] = ($urandom % 10) < 7;
                if (!a_v[i] && ($urandom % 4) == 0) begin
                    logic [5:0] off;
                    off = (($urandom % 4) == 0) ? 6'(56 + $urandom % 8) : 6'($urandom % 64);
                    set_req(i, 1, {26'($urandom), off}, 5'(1 + $urandom % 16),
                            ($urandom % 10) < 6, ($urandom % 2) == 1,
                            ($urandom % 7) == 0, a_dr[i]);
                end
            end
            step();
            chk("R11 one grant", 32'($countones(gnt) <= 1), 1);
            if (m_st != 0) a_v[m_own] = 0;
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule